// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This combinational unit sits beside the decode stage of a 16-bit processor. It looks at one fetched instruction word together with the address that word was fetched from and the four condition flags: negative (N), zero (Z), overflow (V) and carry (C). From these it reports three things. The first is whether the word is a branch, conditional or unconditional. The second is whether that branch is taken. The third is the address the branch would jump to.

The fetch logic uses the two decisions to steer the program counter. The unit holds no state, so its outputs follow its inputs within the same cycle. All pins are plain control and status signals. Nothing is queued here, so there is no valid/ready handshake and no back-pressure.

Branch words have a zero three-bit top field. The next three bits pick a flag expression. Nine bits hold a signed word offset, and the lowest bit picks the expression or its complement. The always-branch encoding uses the first flag group with the lowest bit set. The same group with the lowest bit clear belongs to system instructions, so the unit must not call it a branch.

Top module: `branch_resolver`

## Requirements
- R1: `is_branch` is 1 exactly when bits 15..13 are 000 and the word is not in the system space of R3.
- R2: A word with bits 15..10 = 000000 and bit 0 = 1 is the always-branch: `is_branch` = 1 and `taken` = 1 for every flag value.
- R3: A word with bits 15..10 = 000000 and bit 0 = 0 is a system instruction: `is_branch` = 0 and `taken` = 0 for every flag value.
- R4: A word whose bits 15..13 are not 000 gives `is_branch` = 0 and `taken` = 0 for every flag value.
- R5: Group 001 (bits 12..10) tests the expression Z.
- R6: Group 010 tests N^V (signed less than), and group 011 tests (N^V)|Z (signed less or equal).
- R7: Group 100 tests C (unsigned lower, with C meaning borrow), and group 101 tests C|Z (unsigned lower or same).
- R8: Group 110 tests N, and group 111 tests V.
- R9: For groups 001..111, a branch with bit 0 = 0 is taken when its expression is 1, and a branch with bit 0 = 1 is taken when its expression is 0.
- R10: Whenever `is_branch` = 1, `target` = `pc_addr` + 2 + 2*x. Here x is bits 9..1 read as a two's complement number from -256 to +255, and `pc_addr` is the address of the branch word itself.
- R11: The target sum wraps modulo 2^16, both forwards past 16'hFFFF and backwards below 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Fetched instruction word |
| pc_addr | input | 16 | Address of the fetched word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry / borrow flag |
| is_branch | output | 1 | Word is a conditional or unconditional branch |
| taken | output | 1 | Branch condition holds; always 0 when not a branch |
| target | output | 16 | Branch destination address |

## Verification
The unit is purely combinational, so a fault in its decode or condition logic shows at the ports in the same cycle as the offending word. No earlier stimulus can hide it. Some faults affect only a few of the 16 flag combinations, for example a swapped group code, a dropped Z term in a less-or-equal test, or an inverted polarity bit. Such a fault stays invisible unless those exact combinations are applied, so every group and polarity is crossed with every flag value. A wrong sign extension or a missing wrap in the adder appears only with negative offsets or addresses near the ends of the address space, and the directed vectors aim at those.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    GRP_ALWAYS = 3'd0,
    GRP_ZERO   = 3'd1,
    GRP_SLT    = 3'd2,
    GRP_SLE    = 3'd3,
    GRP_ULT    = 3'd4,
    GRP_ULE    = 3'd5,
    GRP_NEG    = 3'd6,
    GRP_OVF    = 3'd7
  } cond_grp_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam logic [2:0] BRANCH_MAJOR = 3'b000;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              is_branch_o,
  output cond_grp_e         grp_o,
  output logic              invert_o,
  output logic [OFF_W-1:0]  offset_o
);
  localparam int MAJOR_HI = WORD_W - 1;
  localparam int GRP_HI   = WORD_W - 4;

  logic [2:0] major;
  logic       sys_space;

  always_comb begin
    major     = word_i[MAJOR_HI -: 3];
    grp_o     = cond_grp_e'(word_i[GRP_HI -: 3]);
    invert_o  = word_i[0];
    offset_o  = word_i[OFF_W:1];
    sys_space = (grp_o == GRP_ALWAYS) && !invert_o;
    is_branch_o = (major == BRANCH_MAJOR) && !sys_space;
  end

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic      is_branch_i,
  input  cond_grp_e grp_i,
  input  logic      invert_i,
  input  flags_t    flags_i,
  output logic      taken_o
);
  logic expr;
  logic lt_signed;

  always_comb begin
    lt_signed = flags_i.n ^ flags_i.v;
    unique case (grp_i)
      GRP_ALWAYS: expr = 1'b0;
      GRP_ZERO:   expr = flags_i.z;
      GRP_SLT:    expr = lt_signed;
      GRP_SLE:    expr = lt_signed | flags_i.z;
      GRP_ULT:    expr = flags_i.c;
      GRP_ULE:    expr = flags_i.c | flags_i.z;
      GRP_NEG:    expr = flags_i.n;
      GRP_OVF:    expr = flags_i.v;
      default:    expr = 1'b0;
    endcase
    taken_o = is_branch_i && (expr ^ invert_i);
  end

endmodule

// File: rtl/brc_target_add.sv
module brc_target_add #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - OFF_W - 1;

  logic [ADDR_W-1:0] byte_disp;

  always_comb begin
    byte_disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 1'b0};
    target_o  = pc_i + ADDR_W'(2) + byte_disp;
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic [DATA_W-1:0] instr_word,
  input  logic [DATA_W-1:0] pc_addr,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic              is_branch,
  output logic              taken,
  output logic [DATA_W-1:0] target
);
  localparam int TOP_HI = DATA_W - 1;

  cond_grp_e        grp;
  logic             invert;
  logic [OFF_W-1:0] offset;
  flags_t           flags;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brc_decode #(.WORD_W(DATA_W), .OFF_W(OFF_W)) u_decode (
    .word_i      (instr_word),
    .is_branch_o (is_branch),
    .grp_o       (grp),
    .invert_o    (invert),
    .offset_o    (offset)
  );

  brc_cond_eval u_eval (
    .is_branch_i (is_branch),
    .grp_i       (grp),
    .invert_i    (invert),
    .flags_i     (flags),
    .taken_o     (taken)
  );

  brc_target_add #(.ADDR_W(DATA_W), .OFF_W(OFF_W)) u_target (
    .pc_i     (pc_addr),
    .offset_i (offset),
    .target_o (target)
  );

  always_comb begin
    // R4
    taken_major_chk: assert (!taken || instr_word[TOP_HI -: 3] == 3'b000)
      else $error("taken raised outside branch major field");
    // R2
    always_branch_chk: assert (!(instr_word[TOP_HI -: 6] == 6'd0 && instr_word[0]) || taken)
      else $error("always-branch not taken");
    // R3
    sys_space_chk: assert (!(instr_word[TOP_HI -: 6] == 6'd0 && !instr_word[0]) || (!is_branch && !taken))
      else $error("system word reported as branch");
    // R10
    target_even_chk: assert (target[0] == pc_addr[0])
      else $error("target parity differs from pc");
  end

endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;

  logic        clk = 1'b0;
  logic [15:0] instr_word = '0;
  logic [15:0] pc_addr = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic        is_branch, taken;
  logic [15:0] target;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_resolver u_branch_resolver (
    .instr_word (instr_word),
    .pc_addr    (pc_addr),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_v     (flag_v),
    .flag_c     (flag_c),
    .is_branch  (is_branch),
    .taken      (taken),
    .target     (target)
  );

  // entry: instr, pc, NZVC, exp is_branch, exp taken, exp target
  localparam int NVEC = 10;
  localparam logic [53:0] VEC [NVEC] = '{
    {16'h0001, 16'h1000, 4'b0000, 1'b1, 1'b1, 16'h1002}, // R2 x=0
    {16'h03FF, 16'h2000, 4'b1111, 1'b1, 1'b1, 16'h2000}, // R10 x=-1
    {16'h0201, 16'h0100, 4'b0000, 1'b1, 1'b1, 16'hFF02}, // R11 wrap down
    {16'h01FF, 16'hFF00, 4'b0000, 1'b1, 1'b1, 16'h0100}, // R11 wrap up
    {16'h0000, 16'h0040, 4'b1111, 1'b0, 1'b0, 16'h0000}, // R3
    {16'h0002, 16'h0040, 4'b0000, 1'b0, 1'b0, 16'h0000}, // R3
    {16'h8001, 16'h0040, 4'b1111, 1'b0, 1'b0, 16'h0000}, // R4
    {16'h2001, 16'h0040, 4'b1111, 1'b0, 1'b0, 16'h0000}, // R4
    {16'h0400, 16'h0010, 4'b0100, 1'b1, 1'b1, 16'h0012}, // R5 Z set
    {16'h0403, 16'h0010, 4'b0100, 1'b1, 1'b0, 16'h0014}  // R5 inverted
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (instr %h pc %h nzvc %b%b%b%b)",
               req, act, exp, instr_word, pc_addr, flag_n, flag_z, flag_v, flag_c);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
    @(posedge clk);
    instr_word = w;
    pc_addr    = pc;
    {flag_n, flag_z, flag_v, flag_c} = f;
    @(negedge clk);
  endtask

  function automatic logic [15:0] exp_target(input logic [15:0] pc, input logic [8:0] x);
    int sx = (x[8]) ? int'(x) - 512 : int'(x);
    int t  = int'(pc) + 2 + 2 * sx;
    return 16'(t & 32'hFFFF);
  endfunction

  function automatic string grp_tag(input int g);
    case (g)
      1:       return "R5";
      2, 3:    return "R6";
      4, 5:    return "R7";
      6, 7:    return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    // reset state: all-zero inputs form a system word (R3)
    @(negedge clk);
    check("R3 reset is_branch", 16'(is_branch), 16'd0);
    check("R3 reset taken", 16'(taken), 16'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][53:38], VEC[i][37:22], VEC[i][21:18]);
      check("R1 table is_branch", 16'(is_branch), 16'(VEC[i][17]));
      check("R9 table taken", 16'(taken), 16'(VEC[i][16]));
      if (VEC[i][17]) check("R10 table target", target, VEC[i][15:0]);
    end

    // sweep every group, polarity and flag combination
    for (int g = 0; g < 8; g++) begin
      for (int p = 0; p < 2; p++) begin
        for (int f = 0; f < 16; f++) begin
          logic n, z, v, c, e, eb, et;
          logic [15:0] w;
          {n, z, v, c} = 4'(f);
          w = {3'b000, 3'(g), 9'h055, 1'(p)};
          case (g)
            1: e = z;
            2: e = n ^ v;
            3: e = (n ^ v) | z;
            4: e = c;
            5: e = c | z;
            6: e = n;
            7: e = v;
            default: e = 1'b0;
          endcase
          eb = !(g == 0 && p == 0);
          et = eb && (p == 1 ? !e : e);
          apply(w, 16'h4000, 4'(f));
          check(g == 0 ? (p == 0 ? "R3 sweep is_branch" : "R1 sweep is_branch") : "R1 sweep is_branch",
                16'(is_branch), 16'(eb));
          check({grp_tag(g), " R9 sweep taken"}, 16'(taken), 16'(et));
          if (eb) check("R10 sweep target", target, exp_target(16'h4000, 9'h055));
        end
      end
    end

    // non-branch major fields ignore flags (R4)
    for (int t = 1; t < 8; t++) begin
      apply({3'(t), 13'h1FFF}, 16'h0000, 4'b1111);
      check("R4 major is_branch", 16'(is_branch), 16'd0);
      check("R4 major taken", 16'(taken), 16'd0);
    end

    // offset extremes and wrap (R10, R11)
    apply(16'h0201, 16'h8000, 4'b0000);
    check("R10 min offset", target, exp_target(16'h8000, 9'h100));
    apply(16'h01FF, 16'h7FFE, 4'b0000);
    check("R10 max offset", target, exp_target(16'h7FFE, 9'h0FF));
    apply(16'h0001, 16'hFFFE, 4'b0000);
    check("R11 wrap at top", target, 16'h0000);
    apply(16'h03FF, 16'h0000, 4'b0000);
    check("R11 self loop at zero", target, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule